// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block is a non-blocking digital crosspoint: each of `N_OUT` output lanes can carry the data of any one of `N_IN` input lanes. Any input may feed any number of outputs, up to all of them, and no route ever blocks another. Each output can also be switched off. A switched-off output drives high impedance, so several matrices can share one set of output wires.

The routing is held in two register rows. A configuration port writes one output's entry at a time into a pending row. The entry holds an input-select code and an enable bit. While this happens, the live row keeps steering the data path unchanged. A one-cycle commit pulse copies the whole pending row into the live row in one step, so every output changes route on the same clock edge.

Only the two configuration rows are clocked. Data passes from input to output through one combinational multiplexer per output lane. Each lane also exposes its live enable on a flag pin, so its high-impedance state can be observed directly.

Top module: `xpoint_switch`

## Requirements
- R1: With output o enabled and live select s, `dout[o*DATA_W +: DATA_W]` equals `din[s*DATA_W +: DATA_W]`. Each output's select is independent of every other output's select.
- R2: A single input may be selected by several outputs at once, up to all of them, and each of those outputs carries that input's data.
- R3: When the rising edge has `commit` low, the live routing (`dout` selection and `out_en`) is unchanged, even if a pending-row write happens on that edge.
- R4: On a rising edge with `commit` high, the whole pending row becomes the live row. All outputs take their new route and enable together, in the cycle after that edge.
- R5: An output whose live enable bit is 0 drives all bits of its `dout` lane as high impedance and shows 0 on `out_en[o]`. An enabled output shows 1 on `out_en[o]`.
- R6: A valid write (`cfg_wr`=1) sets the pending entry of output `cfg_out` to `cfg_sel`/`cfg_en` and changes no other output's pending entry.
- R7: When a valid write and `commit` fall on the same edge, the live row receives the pending contents from before that write. The write lands in the pending row only and goes live at a later commit.
- R8: A write whose `cfg_out` is N_OUT or more, or whose `cfg_sel` is N_IN or more, is ignored and leaves the pending row unchanged.
- R9: Reset (`rst_n` low on a rising edge) clears both rows to all outputs disabled. Every output is high impedance after reset, and stays so after a commit that has no prior writes.
- R10: A change on `din` reaches `dout` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration rows |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Pending-row write strobe |
| cfg_out | input | OIDX_W (3) | Output index being written |
| cfg_sel | input | SEL_W (3) | Input-select code for that output |
| cfg_en | input | 1 | Enable bit for that output |
| commit | input | 1 | Copy the pending row into the live row |
| din | input | N_IN*DATA_W (48) | Input lanes, lane i at bits i*DATA_W upward |
| dout | output | N_OUT*DATA_W (40) | Tri-state output lanes, lane o at bits o*DATA_W upward |
| out_en | output | N_OUT (5) | Live enable of each output |

## Verification
Directed patterns cover three cases. One routes every output to one input, which shows fan-out to all outputs (R2) apart from a shifted one-to-one map (R1). One writes a single output, which separates per-entry writes from row-wide ones. One lands a write on the same edge as a commit, which shows whether the old or the new pending value goes live. Out-of-range indices and selects, and a commit straight after reset, show whether the guard logic and reset clear the pending row as well as the live one. Random writes, commits and input data, some with invalid fields, are checked every cycle against a two-row model in the bench. These runs show up any route that changes before a commit or any lane that commits late.

// File: rtl/xp_pkg.sv
// Package: shared helpers for the crosspoint switch.
// Assumes: counts passed in are at least 1.
package xp_pkg;
    // Width of an index field that can address n items, never below 1.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xp_cfg_rows.sv
// Module: holds the pending (shadow) and live routing rows.
// A write updates one pending entry; a commit copies the whole pending
// row into the live row on one edge.
// Assumes: synchronous active-low reset; cfg fields are sampled on clk.
module xp_cfg_rows #(
    parameter int N_IN   = 6,
    parameter int N_OUT  = 5,
    parameter int SEL_W  = 3,
    parameter int OIDX_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [OIDX_W-1:0]             wr_idx,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic                          wr_en,
    input  logic                          commit,
    output logic [N_OUT-1:0][SEL_W-1:0]   live_sel,
    output logic [N_OUT-1:0]              live_en
);
    logic [N_OUT-1:0][SEL_W-1:0] shd_sel;
    logic [N_OUT-1:0]            shd_en;
    logic                        wr_ok;

    // Accept a write only when both fields are in range.
    always_comb begin
        wr_ok = wr && (int'(wr_idx) < N_OUT) && (int'(wr_sel) < N_IN);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_entry
        // Pending entry o: reset to disabled, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd_sel[o] <= '0;
                shd_en[o]  <= 1'b0;
            end else if (wr_ok && (wr_idx == OIDX_W'(o))) begin
                shd_sel[o] <= wr_sel;
                shd_en[o]  <= wr_en;
            end
        end

        AST_OTHER_ENTRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_ok || (wr_idx != OIDX_W'(o))) |=> ($stable(shd_sel[o]) && $stable(shd_en[o])))
            else $error("pending entry changed without addressed write"); // R6
    end

    // Live row: reset to disabled, copy the whole pending row on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_sel <= '0;
            live_en  <= '0;
        end else if (commit) begin
            live_sel <= shd_sel;
            live_en  <= shd_en;
        end
    end

    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(live_sel) && $stable(live_en)))
        else $error("live row changed without commit"); // R3

    AST_COMMIT_OLD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((live_sel == $past(shd_sel)) && (live_en == $past(shd_en))))
        else $error("commit did not copy pre-write pending row"); // R7

    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ((int'(wr_idx) >= N_OUT) || (int'(wr_sel) >= N_IN)))
            |=> ($stable(shd_sel) && $stable(shd_en)))
        else $error("out-of-range write altered pending row"); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((live_en == '0) && (shd_en == '0)))
        else $error("rows not cleared by reset"); // R9
endmodule

// File: rtl/xp_out_lane.sv
// Module: one output lane; a combinational input multiplexer followed
// by a tri-state driver controlled by the live enable.
// Assumes: sel is below N_IN whenever en is 1 (guaranteed by the rows).
module xp_out_lane #(
    parameter int N_IN   = 6,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic [N_IN*DATA_W-1:0] din,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   en,
    output logic [DATA_W-1:0]      dout
);
    logic [DATA_W-1:0] pick;

    // Select the addressed input lane.
    always_comb begin
        pick = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == SEL_W'(i)) pick = din[i*DATA_W +: DATA_W];
        end
    end

    // Drive the lane or release it to high impedance.
    assign dout = en ? pick : {DATA_W{1'bz}};
endmodule

// File: rtl/xpoint_switch.sv
// Module: top of the double-buffered crosspoint switch.
// Assumes: synchronous active-low reset; din lane i at bits i*DATA_W up,
// dout lane o at bits o*DATA_W up.
module xpoint_switch
    import xp_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_OUT  = 5,
    parameter int DATA_W = 8,
    localparam int SEL_W  = idx_w(N_IN),
    localparam int OIDX_W = idx_w(N_OUT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [OIDX_W-1:0]       cfg_out,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic                    cfg_en,
    input  logic                    commit,
    input  logic [N_IN*DATA_W-1:0]  din,
    output logic [N_OUT*DATA_W-1:0] dout,
    output logic [N_OUT-1:0]        out_en
);
    logic [N_OUT-1:0][SEL_W-1:0] live_sel;
    logic [N_OUT-1:0]            live_en;

    xp_cfg_rows #(
        .N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .OIDX_W(OIDX_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .wr_idx(cfg_out), .wr_sel(cfg_sel), .wr_en(cfg_en),
        .commit(commit),
        .live_sel(live_sel), .live_en(live_en)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        xp_out_lane #(
            .N_IN(N_IN), .SEL_W(SEL_W), .DATA_W(DATA_W)
        ) u_lane (
            .din(din), .sel(live_sel[o]), .en(live_en[o]),
            .dout(dout[o*DATA_W +: DATA_W])
        );
    end

    assign out_en = live_en;
endmodule

// File: tb/xpoint_switch_bench.sv
module xpoint_switch_bench;
    localparam int N_IN = 6, N_OUT = 5, W = 8, SW = 3, OW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_en = 1'b0, commit = 1'b0;
    logic [OW-1:0] cfg_out = '0;
    logic [SW-1:0] cfg_sel = '0;
    logic [N_IN*W-1:0]  din = '0;
    logic [N_OUT*W-1:0] dout;
    logic [N_OUT-1:0]   out_en;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Bench model of both rows.
    int m_shd_sel[N_OUT], m_act_sel[N_OUT];
    bit m_shd_en[N_OUT],  m_act_en[N_OUT];

    always #5 clk = ~clk;

    xpoint_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(W)) u_xpoint_switch (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_out(cfg_out),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .commit(commit),
        .din(din), .dout(dout), .out_en(out_en)
    );

    function automatic logic [W-1:0] exp_lane(int o);
        if (!m_act_en[o]) return {W{1'bz}};
        return din[m_act_sel[o]*W +: W];
    endfunction

    task automatic check_all(string tag);
        tests++;
        for (int o = 0; o < N_OUT; o++) begin
            if (dout[o*W +: W] !== exp_lane(o) || out_en[o] !== m_act_en[o]) begin
                fails++;
                $display("FAIL %s out%0d: dout=%h en=%b expected dout=%h en=%b",
                         tag, o, dout[o*W +: W], out_en[o], exp_lane(o), m_act_en[o]);
            end
        end
    endtask

    // One clock: apply the given controls, update the model after the edge.
    task automatic step(bit wr, int idx, int sel, bit en, bit cm);
        cfg_wr = wr; cfg_out = OW'(idx); cfg_sel = SW'(sel); cfg_en = en; commit = cm;
        @(posedge clk);
        #2;
        if (cm) begin
            for (int o = 0; o < N_OUT; o++) begin
                m_act_sel[o] = m_shd_sel[o];
                m_act_en[o]  = m_shd_en[o];
            end
        end
        if (wr && idx < N_OUT && sel < N_IN) begin
            m_shd_sel[idx] = sel;
            m_shd_en[idx]  = en;
        end
        cfg_wr = 1'b0; commit = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234));
        for (int o = 0; o < N_OUT; o++) begin
            m_shd_sel[o] = 0; m_shd_en[o] = 0; m_act_sel[o] = 0; m_act_en[o] = 0;
        end
        for (int i = 0; i < N_IN; i++) din[i*W +: W] = W'(8'h11 * (i + 1));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        check_all("R9 reset");
        step(0, 0, 0, 0, 1);
        check_all("R9 commit after reset");

        // R2: all outputs to input 2; live row unchanged until commit (R3).
        for (int o = 0; o < N_OUT; o++) begin
            step(1, o, 2, 1, 0);
            check_all("R3 pending write");
        end
        step(0, 0, 0, 0, 1);
        check_all("R2 fan-out all");
        check_all("R4 commit");

        // R10: input change without a clock.
        din[2*W +: W] = 8'hA5;
        #1 check_all("R10 comb path");

        // R1: distinct map o -> (o+1) mod N_IN.
        for (int o = 0; o < N_OUT; o++) step(1, o, (o + 1) % N_IN, 1, 0);
        step(0, 0, 0, 0, 1);
        check_all("R1 independent map");

        // R6: single entry write.
        step(1, 1, 5, 1, 0);
        step(0, 0, 0, 0, 1);
        check_all("R6 single entry");

        // R7: write on commit edge goes to pending only.
        step(1, 0, 4, 1, 1);
        check_all("R7 old row live");
        step(0, 0, 0, 0, 1);
        check_all("R7 write later live");

        // R8: out-of-range index and select.
        step(1, 5, 1, 0, 0);
        step(1, 7, 0, 0, 0);
        step(1, 2, 6, 0, 0);
        step(1, 3, 7, 0, 0);
        step(0, 0, 0, 0, 1);
        check_all("R8 ignored writes");

        // R5: disable output 3.
        step(1, 3, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        check_all("R5 disabled Z");

        // Random mix of writes, commits and data.
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N_IN; i++) din[i*W +: W] = W'($urandom);
            step(($urandom % 3) != 0, $urandom % 8, $urandom % 8, $urandom % 2,
                 ($urandom % 4) == 0);
            check_all("R4 random");
        end

        // R9: reset mid-run clears both rows.
        rst_n = 1'b0;
        @(posedge clk);
        #2 rst_n = 1'b1;
        for (int o = 0; o < N_OUT; o++) begin
            m_shd_sel[o] = 0; m_shd_en[o] = 0; m_act_sel[o] = 0; m_act_en[o] = 0;
        end
        check_all("R9 mid reset");
        step(0, 0, 0, 0, 1);
        check_all("R9 pending cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule